// File: doc/BRIEF.md
# Lookahead carry generator

This block is a purely combinational carry lookahead unit for wide adders built from small arithmetic slices. Each of up to four slices (or groups of slices) reports whether it passes an incoming carry through (propagate) and whether it creates a carry on its own (generate). Both signals are low-true. From these, and from a positive-logic carry into the least significant group, the unit forms the carries into the three upper groups in a single two-level logic step. It does not wait for a carry to ripple from group to group.

The unit also condenses its four groups into one low-true propagate/generate pair. A second level of the same unit can therefore treat four first-level units as four groups. A tree of five units, four on the first level and one above them, spans sixteen 4-bit slices, which gives a 64-bit adder or subtractor. The carries into the upper groups do not use the most significant group's propagate or generate. The top slice of a full word therefore never has to produce those signals.

Top module: `lookahead_carry_unit`

## Requirements
- R1: `carry_up[0]` (carry into group 1) is high exactly when group 0 generates (`grp_gen_n[0]` low), or when group 0 propagates (`grp_prop_n[0]` low) and `carry_in` is high.
- R2: `carry_up[1]` (carry into group 2) is high exactly when group 1 generates, or when group 1 propagates and `carry_up[0]` is high.
- R3: `carry_up[2]` (carry into group 3) is high exactly when group 2 generates, or when group 2 propagates and `carry_up[1]` is high.
- R4: Changing `grp_prop_n[3]` or `grp_gen_n[3]` has no effect on any bit of `carry_up`.
- R5: `blk_prop_n` is low exactly when all four `grp_prop_n` bits are low.
- R6: `blk_gen_n` is low exactly when some group k generates and every group above k propagates. Group 3 generating on its own drives it low.
- R7: `blk_prop_n` and `blk_gen_n` do not depend on `carry_in`.
- R8: With every propagate and generate input high (inactive), all `carry_up` bits are low and both block outputs are high, whatever the value of `carry_in`.
- R9: Five units wired as a two-level tree over sixteen 4-bit slices give the correct 64-bit sum and carry-out for addition. For subtraction, the second operand is inverted and `carry_in` is high, and the result is the correct difference with carry-out high when no borrow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grp_prop_n | input | 4 | Low-true propagate per group; bit 0 is the least significant group |
| grp_gen_n | input | 4 | Low-true generate per group; bit 0 is the least significant group |
| carry_in | input | 1 | Positive-logic carry into group 0 |
| carry_up | output | 3 | Positive-logic carries into groups 1, 2 and 3 (bit 0 feeds group 1) |
| blk_prop_n | output | 1 | Low-true propagate of the four groups taken together |
| blk_gen_n | output | 1 | Low-true generate of the four groups taken together |

## Verification
The upper carries and the block generate output are both formed from the same generate inputs in the same evaluation. One input change can therefore move both at once, or move only one of them. The bench provokes this by asserting group 3's generate and propagate while holding the lower groups fixed. It judges that the block generate follows while `carry_up` stays unchanged. It also toggles `carry_in` under fixed propagate/generate inputs and checks that the carries move while the block pair holds. The full tree then exercises both paths together: every 64-bit result depends on the block outputs of the first level and on the carries returned from the second level.

// File: rtl/lookahead_carry_pkg.sv
// Package: shared constants for the lookahead carry unit.
// Assumes callers keep the group count between 2 and 8.
package lookahead_carry_pkg;
    // Number of groups served by one unit
    localparam int unsigned LCU_GROUPS = 4;
    // Width of the upward carry bus (one per group above the lowest)
    localparam int unsigned LCU_UP_W = LCU_GROUPS - 1;
endpackage

// File: rtl/lcu_polarity_in.sv
// Module: lcu_polarity_in
// Converts the low-true propagate/generate inputs into true-sense vectors.
// Assumes inputs are plain levels; no registering.
module lcu_polarity_in #(
    parameter int unsigned GROUPS = 4
) (
    input  logic [GROUPS-1:0] prop_n,
    input  logic [GROUPS-1:0] gen_n,
    output logic [GROUPS-1:0] prop,
    output logic [GROUPS-1:0] gen
);
    // One inverter pair per group
    for (genvar i = 0; i < GROUPS; i++) begin : g_inv
        assign prop[i] = ~prop_n[i];
        assign gen[i]  = ~gen_n[i];
    end
endmodule

// File: rtl/lcu_carry_net.sv
// Module: lcu_carry_net
// Forms the carry into each group above group 0 as a flat sum of products.
// Carry j uses only groups 0..j-1, so the top group never enters any term.
module lcu_carry_net #(
    parameter int unsigned GROUPS = 4,
    localparam int unsigned UP_W = GROUPS - 1
) (
    input  logic [GROUPS-1:0] prop,
    input  logic [GROUPS-1:0] gen,
    input  logic              cin,
    output logic [UP_W-1:0]   carry
);
    for (genvar j = 1; j < GROUPS; j++) begin : g_carry
        // Sum of products for the carry entering group j
        always_comb begin
            logic sop;
            logic term;
            term = cin;
            for (int m = 0; m < j; m++) term = term & prop[m];
            sop = term;
            for (int k = 0; k < j; k++) begin
                term = gen[k];
                for (int m = k + 1; m < j; m++) term = term & prop[m];
                sop = sop | term;
            end
            carry[j-1] = sop;
        end
    end
endmodule

// File: rtl/lcu_block_pg.sv
// Module: lcu_block_pg
// Condenses all groups into one low-true propagate/generate pair for the
// next tree level. Independent of the carry input by construction.
module lcu_block_pg #(
    parameter int unsigned GROUPS = 4
) (
    input  logic [GROUPS-1:0] prop,
    input  logic [GROUPS-1:0] gen,
    output logic              blk_prop_n,
    output logic              blk_gen_n
);
    // Block propagate: every group must pass the carry
    always_comb blk_prop_n = ~(&prop);

    // Block generate: some group creates a carry that all higher groups pass
    always_comb begin
        logic sop;
        logic term;
        sop = 1'b0;
        for (int k = 0; k < GROUPS; k++) begin
            term = gen[k];
            for (int m = k + 1; m < GROUPS; m++) term = term & prop[m];
            sop = sop | term;
        end
        blk_gen_n = ~sop;
    end
endmodule

// File: rtl/lookahead_carry_unit.sv
// Module: lookahead_carry_unit (top)
// Combinational carry lookahead for four groups with low-true
// propagate/generate on both sides and positive-logic carries.
// Assumes no clock or reset: outputs follow inputs directly.
module lookahead_carry_unit
    import lookahead_carry_pkg::*;
(
    input  logic [LCU_GROUPS-1:0] grp_prop_n,
    input  logic [LCU_GROUPS-1:0] grp_gen_n,
    input  logic                  carry_in,
    output logic [LCU_UP_W-1:0]   carry_up,
    output logic                  blk_prop_n,
    output logic                  blk_gen_n
);
    logic [LCU_GROUPS-1:0] prop_t;
    logic [LCU_GROUPS-1:0] gen_t;

    lcu_polarity_in #(.GROUPS(LCU_GROUPS)) u_pol (
        .prop_n (grp_prop_n),
        .gen_n  (grp_gen_n),
        .prop   (prop_t),
        .gen    (gen_t)
    );

    lcu_carry_net #(.GROUPS(LCU_GROUPS)) u_carry (
        .prop  (prop_t),
        .gen   (gen_t),
        .cin   (carry_in),
        .carry (carry_up)
    );

    lcu_block_pg #(.GROUPS(LCU_GROUPS)) u_blk (
        .prop       (prop_t),
        .gen        (gen_t),
        .blk_prop_n (blk_prop_n),
        .blk_gen_n  (blk_gen_n)
    );
endmodule

// File: rtl/lookahead_carry_unit_chk.sv
// Module: lookahead_carry_unit_chk
// Immediate checks on port relations of the lookahead unit; the block has
// no clock, so each check is evaluated whenever its inputs settle.
module lookahead_carry_unit_chk (
    input logic [3:0] grp_prop_n,
    input logic [3:0] grp_gen_n,
    input logic       carry_in,
    input logic [2:0] carry_up,
    input logic       blk_prop_n,
    input logic       blk_gen_n
);
    // Relate each carry to its own group and the carry below it
    always_comb begin
        if (!grp_gen_n[0])
            a_r1_gen_sets_carry: assert (carry_up[0]);
        if (grp_gen_n[0] && (grp_prop_n[0] || !carry_in))
            a_r1_no_source: assert (!carry_up[0]);
        if (carry_up[1])
            a_r2_has_source: assert (!grp_gen_n[1] || (!grp_prop_n[1] && carry_up[0]));
        if (carry_up[2])
            a_r3_has_source: assert (!grp_gen_n[2] || (!grp_prop_n[2] && carry_up[1]));
        if (!blk_prop_n)
            a_r5_all_pass: assert ($countones(grp_prop_n) == 0);
        if (!grp_gen_n[3])
            a_r6_top_gen: assert (!blk_gen_n);
        if (grp_prop_n == 4'hF && grp_gen_n == 4'hF)
            a_r8_idle: assert (carry_up == 3'b000 && blk_prop_n && blk_gen_n);
    end
endmodule

bind lookahead_carry_unit lookahead_carry_unit_chk u_chk (
    .grp_prop_n (grp_prop_n),
    .grp_gen_n  (grp_gen_n),
    .carry_in   (carry_in),
    .carry_up   (carry_up),
    .blk_prop_n (blk_prop_n),
    .blk_gen_n  (blk_gen_n)
);

// File: tb/lookahead_carry_unit_tb.sv
// Bench: table-driven checks of one unit, directed corner cases, then a
// 64-bit adder made of sixteen 4-bit slice models and a tree of five units.
module lookahead_carry_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Single unit under table test
    logic [3:0] pn, gn;
    logic       ci;
    logic [2:0] up;
    logic       bpn, bgn;

    lookahead_carry_unit u_dut (
        .grp_prop_n (pn), .grp_gen_n (gn), .carry_in (ci),
        .carry_up (up), .blk_prop_n (bpn), .blk_gen_n (bgn)
    );

    typedef struct packed {
        logic [3:0] pn;
        logic [3:0] gn;
        logic       ci;
        logic [2:0] up;
        logic       bpn;
        logic       bgn;
    } vec_t;

    // Inputs low-true, up = {carry into g3, g2, g1}
    localparam vec_t VEC [10] = '{
        '{4'b1111, 4'b1111, 1'b1, 3'b000, 1'b1, 1'b1},
        '{4'b0000, 4'b1111, 1'b1, 3'b111, 1'b0, 1'b1},
        '{4'b0000, 4'b1111, 1'b0, 3'b000, 1'b0, 1'b1},
        '{4'b1111, 4'b1110, 1'b0, 3'b001, 1'b1, 1'b1},
        '{4'b0001, 4'b1110, 1'b0, 3'b111, 1'b1, 1'b0},
        '{4'b0000, 4'b0111, 1'b0, 3'b000, 1'b0, 1'b0},
        '{4'b1111, 4'b1011, 1'b1, 3'b100, 1'b1, 1'b1},
        '{4'b1011, 4'b1101, 1'b0, 3'b110, 1'b1, 1'b1},
        '{4'b0101, 4'b1110, 1'b1, 3'b011, 1'b1, 1'b1},
        '{4'b1000, 4'b1111, 1'b1, 3'b111, 1'b1, 1'b1}
    };

    // ---------------- 64-bit tree ----------------
    logic [63:0] op_a, op_b, op_b_eff;
    logic        op_sub;
    logic        t_cin;
    logic [15:0] sl_pn, sl_gn, sl_cin;
    logic [2:0]  l1_up [4];
    logic [3:0]  l1_bpn, l1_bgn;
    logic [2:0]  top_up;
    logic        top_bpn, top_bgn;
    logic [63:0] t_sum;
    logic        t_cout;

    assign op_b_eff = op_sub ? ~op_b : op_b;
    assign t_cin    = op_sub;

    // Slice models: 4-bit propagate/generate from the operands
    for (genvar s = 0; s < 16; s++) begin : g_slice
        logic [4:0] raw;
        assign raw       = {1'b0, op_a[4*s+:4]} + {1'b0, op_b_eff[4*s+:4]};
        assign sl_gn[s]  = ~raw[4];
        assign sl_pn[s]  = ~(&(op_a[4*s+:4] | op_b_eff[4*s+:4]));
        assign t_sum[4*s+:4] = op_a[4*s+:4] + op_b_eff[4*s+:4] + {3'b000, sl_cin[s]};
    end

    for (genvar k = 0; k < 4; k++) begin : g_l1
        lookahead_carry_unit u_l1 (
            .grp_prop_n (sl_pn[4*k+:4]), .grp_gen_n (sl_gn[4*k+:4]),
            .carry_in (sl_cin[4*k]), .carry_up (l1_up[k]),
            .blk_prop_n (l1_bpn[k]), .blk_gen_n (l1_bgn[k])
        );
        for (genvar j = 1; j < 4; j++) begin : g_cw
            assign sl_cin[4*k+j] = l1_up[k][j-1];
        end
        if (k == 0) begin : g_base
            assign sl_cin[0] = t_cin;
        end else begin : g_upper
            assign sl_cin[4*k] = top_up[k-1];
        end
    end

    lookahead_carry_unit u_top (
        .grp_prop_n (l1_bpn), .grp_gen_n (l1_bgn), .carry_in (t_cin),
        .carry_up (top_up), .blk_prop_n (top_bpn), .blk_gen_n (top_bgn)
    );

    assign t_cout = ~top_bgn | (~top_bpn & t_cin);

    // Record one check; print FAIL line on mismatch
    task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive single-unit inputs after a rising edge, sample on the falling edge
    task automatic drive_unit(input logic [3:0] p, input logic [3:0] g, input logic c);
        @(posedge clk);
        pn = p; gn = g; ci = c;
        @(negedge clk);
    endtask

    // Apply one tree operation and compare against a 65-bit reference
    task automatic tree_op(input logic [63:0] a, input logic [63:0] b, input bit sub);
        logic [64:0] exp;
        @(posedge clk);
        op_a = a; op_b = b; op_sub = sub;
        @(negedge clk);
        exp = sub ? ({1'b0, a} + {1'b0, ~b} + 65'd1) : ({1'b0, a} + {1'b0, b});
        check({t_cout, t_sum} == exp, "R9 tree result", {t_cout, t_sum}, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        pn = 4'hF; gn = 4'hF; ci = 1'b0;
        op_a = '0; op_b = '0; op_sub = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: idle inputs during reset
        check(up == 3'b000 && bpn && bgn, "R8 idle at reset", {up, bpn, bgn}, {3'b000, 2'b11});
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R5 R6 R8
        foreach (VEC[i]) begin
            drive_unit(VEC[i].pn, VEC[i].gn, VEC[i].ci);
            check({up, bpn, bgn} == {VEC[i].up, VEC[i].bpn, VEC[i].bgn},
                  "R1/R2/R3/R5/R6 table vector", {up, bpn, bgn}, {VEC[i].up, VEC[i].bpn, VEC[i].bgn});
        end

        // R4: group 3 inputs swept, carries fixed at 011
        for (int v = 0; v < 4; v++) begin
            drive_unit({v[0], 3'b101}, {v[1], 3'b110}, 1'b1);
            check(up == 3'b011, "R4 top group ignored", {62'd0, up}, 65'd3);
        end
        // R4 and R6 together: G3 alone drives block generate, carries unchanged
        drive_unit(4'b0111, 4'b0111, 1'b0);
        check(up == 3'b000 && !bgn, "R4 R6 top generate", {up, bgn}, {3'b000, 1'b0});

        // R7: carry_in toggled under fixed groups
        for (int c = 0; c < 2; c++) begin
            drive_unit(4'b0001, 4'b1110, c[0]);
            check(bpn == 1'b1 && bgn == 1'b0, "R7 block pair ignores carry_in", {bpn, bgn}, 2'b10);
        end
        // R1: propagate only, carry follows carry_in
        drive_unit(4'b1110, 4'b1111, 1'b1);
        check(up == 3'b001, "R1 propagate passes carry_in", {62'd0, up}, 65'd1);
        // R8: idle with carry_in high
        drive_unit(4'hF, 4'hF, 1'b1);
        check(up == 3'b000 && bpn && bgn, "R8 idle carry_in high", {up, bpn, bgn}, {3'b000, 2'b11});

        // R9: tree corner cases
        tree_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
        tree_op(64'h0FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
        tree_op(64'd0, 64'd0, 1'b1);
        tree_op(64'd5, 64'd9, 1'b1);
        tree_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        // R9: random sums and differences
        for (int r = 0; r < 200; r++) begin
            tree_op({$urandom, $urandom}, {$urandom, $urandom}, r[0]);
        end
        finish_run();
    end
endmodule